// File: doc/BRIEF.md
# SIMD Single-Source Compare, Absolute Value and Negate Unit

This unit executes a small family of single-source vector instructions. Each accepted request carries a 32-bit instruction word and a 128-bit source vector. The unit extracts the operation, element width and vector length from the instruction. It then applies the operation to every lane of the source and returns a 128-bit result one clock later, together with the destination register index and a flag that marks an illegal encoding.

Five operations compare each lane, read as a signed integer, against zero. Each lane of the result is then all ones or all zeros. The two arithmetic operations return the absolute value or the negation of each lane. Both wrap modulo the element width and do not saturate. Elements are 8, 16, 32 or 64 bits wide. A half-width instruction works on the low 64 bits only and writes zeros to the upper half of the result. Register file access and writeback belong to the surrounding pipeline.

Top module: `simd_cmpabs_unit`

## Requirements
- R1: The opcode is taken from instruction bits [16:12], the U flag from bit 29, the Q flag from bit 30 and the size code from bits [23:22], where 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Bits [4:0] are returned unchanged on `out_dst`.
- R2: Opcode 0x8 with U=0 tests lane > 0 and with U=1 tests lane >= 0. Opcode 0x9 with U=0 tests lane == 0 and with U=1 tests lane <= 0. Opcode 0xA with U=0 tests lane < 0. Every test is signed. A lane that passes gives all ones and any other lane gives all zeros.
- R3: Opcode 0xB with U=0 returns a lane unchanged when it is greater than zero and returns its two's-complement negation otherwise, so the most negative value maps to itself.
- R4: Opcode 0xB with U=1 returns zero minus the lane modulo the element width, with no saturation.
- R5: Size code 3 with Q=0 raises `out_illegal` for every opcode.
- R6: An opcode outside 0x8..0xB, or opcode 0xA with U=1, raises `out_illegal`. Whenever `out_illegal` is high the result is all zeros.
- R7: With Q=1 all 128 bits are processed. With Q=0 only the low 64 bits are processed and bits [127:64] of the result are zero.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result, destination and flag registered in that cycle stay unchanged while `in_valid` is low.
- R9: While reset is asserted, `out_valid`, `out_vec`, `out_dst` and `out_illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| out_valid | output | 1 | Result present this cycle |
| out_vec | output | 128 | Result vector |
| out_dst | output | 5 | Destination register index |
| out_illegal | output | 1 | Encoding is not allowed |

## Verification
Random source vectors are drawn in four patterns. Fully random data mostly exercises the strictly positive and negative paths. All-zero vectors separate the strict tests from the non-strict ones (greater-than from greater-or-equal, less-than from less-or-equal). Sparse vectors mix zero and non-zero lanes within one vector, so lane boundaries at every element size are tested. Vectors built from the byte values 0x00, 0x01, 0x7F, 0x80 and 0xFF reach the most negative and most positive lanes, where absolute value and negation wrap. Directed cases pin the wrap values, the two illegal encodings and the hold behaviour when no request is present.

// File: rtl/simd_cmpabs_pkg.sv
package simd_cmpabs_pkg;

    localparam int VEC_W      = 128;
    localparam int INSN_W     = 32;
    localparam int REG_IDX_W  = 5;
    localparam int SIZE_CODES = 4;

    typedef enum logic [2:0] {
        OP_GT   = 3'd0,
        OP_GE   = 3'd1,
        OP_EQ   = 3'd2,
        OP_LE   = 3'd3,
        OP_LT   = 3'd4,
        OP_ABS  = 3'd5,
        OP_NEG  = 3'd6,
        OP_NONE = 3'd7
    } lane_op_e;

    typedef struct packed {
        logic                 valid;
        logic [VEC_W-1:0]     vec;
        logic [REG_IDX_W-1:0] dst;
        logic                 illegal;
    } out_regs_t;

endpackage

// File: rtl/simd_field_decode.sv
module simd_field_decode
    import simd_cmpabs_pkg::*;
#(
    parameter int INSN_BITS = INSN_W,
    parameter int IDX_BITS  = REG_IDX_W
) (
    input  logic [INSN_BITS-1:0] insn,
    output lane_op_e             op,
    output logic [1:0]           size_code,
    output logic                 full_q,
    output logic [IDX_BITS-1:0]  dst_idx,
    output logic                 illegal
);

    logic [4:0] opcode;
    logic       u_flag;

    // R1: fixed field positions
    assign opcode    = insn[16:12];
    assign u_flag    = insn[29];
    assign full_q    = insn[30];
    assign size_code = insn[23:22];
    assign dst_idx   = insn[IDX_BITS-1:0];

    logic unused_insn_bits;
    assign unused_insn_bits = ^{insn[INSN_BITS-1], insn[28:24], insn[21:17], insn[11:IDX_BITS]};

    always_comb begin
        case (opcode)
            5'h08:   op = u_flag ? OP_GE  : OP_GT;
            5'h09:   op = u_flag ? OP_LE  : OP_EQ;
            5'h0A:   op = u_flag ? OP_NONE : OP_LT;
            5'h0B:   op = u_flag ? OP_NEG : OP_ABS;
            default: op = OP_NONE;
        endcase
        illegal = (op == OP_NONE) || ((size_code == 2'd3) && !full_q);
    end

endmodule

// File: rtl/simd_lane_op.sv
module simd_lane_op
    import simd_cmpabs_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  lane_op_e          op,
    input  logic [ELEM_W-1:0] a,
    output logic [ELEM_W-1:0] y
);

    logic              is_neg;
    logic              is_zero;
    logic              is_pos;
    logic [ELEM_W-1:0] negated;

    assign is_neg  = a[ELEM_W-1];
    assign is_zero = (a == '0);
    assign is_pos  = !is_neg && !is_zero;
    assign negated = '0 - a;

    always_comb begin
        case (op)
            OP_GT:   y = {ELEM_W{is_pos}};
            OP_GE:   y = {ELEM_W{!is_neg}};
            OP_EQ:   y = {ELEM_W{is_zero}};
            OP_LE:   y = {ELEM_W{is_neg || is_zero}};
            OP_LT:   y = {ELEM_W{is_neg}};
            OP_ABS:  y = is_pos ? a : negated;
            OP_NEG:  y = negated;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_size_slice.sv
module simd_size_slice
    import simd_cmpabs_pkg::*;
#(
    parameter int DATA_W = VEC_W,
    parameter int ELEM_W = 8
) (
    input  lane_op_e          op,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);

    localparam int LANES = DATA_W / ELEM_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        simd_lane_op #(.ELEM_W(ELEM_W)) u_lane (
            .op (op),
            .a  (src[l*ELEM_W +: ELEM_W]),
            .y  (res[l*ELEM_W +: ELEM_W])
        );
    end

endmodule

// File: rtl/simd_cmpabs_unit.sv
module simd_cmpabs_unit
    import simd_cmpabs_pkg::*;
#(
    parameter int DATA_W    = VEC_W,
    parameter int INSN_BITS = INSN_W,
    parameter int IDX_BITS  = REG_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSN_BITS-1:0] insn,
    input  logic [DATA_W-1:0]    src_vec,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_vec,
    output logic [IDX_BITS-1:0]  out_dst,
    output logic                 out_illegal
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_HALF = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    lane_op_e            dec_op;
    logic [1:0]          dec_size;
    logic                dec_q;
    logic [IDX_BITS-1:0] dec_dst;
    logic                dec_illegal;

    simd_field_decode #(.INSN_BITS(INSN_BITS), .IDX_BITS(IDX_BITS)) u_decode (
        .insn      (insn),
        .op        (dec_op),
        .size_code (dec_size),
        .full_q    (dec_q),
        .dst_idx   (dec_dst),
        .illegal   (dec_illegal)
    );

    logic [DATA_W-1:0] per_size [SIZE_CODES];

    for (genvar s = 0; s < SIZE_CODES; s++) begin : g_size
        simd_size_slice #(.DATA_W(DATA_W), .ELEM_W(8 << s)) u_slice (
            .op  (dec_op),
            .src (src_vec),
            .res (per_size[s])
        );
    end

    out_regs_t         state_d;
    out_regs_t         state_q;
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = per_size[dec_size];
        if (!dec_q)      picked = picked & LOW_HALF;
        if (dec_illegal) picked = '0;

        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.vec     = picked;
            state_d.dst     = dec_dst;
            state_d.illegal = dec_illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_vec     = state_q.vec;
    assign out_dst     = state_q.dst;
    assign out_illegal = state_q.illegal;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_dst) && $stable(out_illegal)));

    // R5
    wide_half_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[23:22] == 2'd3 && !insn[30]) |=> out_illegal);

    // R6
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_vec == '0));

    // R7
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !insn[30]) |=> (out_vec[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/simd_cmpabs_unit_tb_top.sv
module simd_cmpabs_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [31:0]  insn;
    logic [127:0] src_vec;
    logic         out_valid;
    logic [127:0] out_vec;
    logic [4:0]   out_dst;
    logic         out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_cmpabs_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .insn        (insn),
        .src_vec     (src_vec),
        .out_valid   (out_valid),
        .out_vec     (out_vec),
        .out_dst     (out_dst),
        .out_illegal (out_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int opc, input bit u, input bit q,
                                       input int sz, input int dst, input logic [31:0] fill);
        logic [31:0] r;
        r        = fill;
        r[16:12] = opc[4:0];
        r[29]    = u;
        r[30]    = q;
        r[23:22] = sz[1:0];
        r[4:0]   = dst[4:0];
        return r;
    endfunction

    function automatic logic [127:0] model(input logic [31:0] ins, input logic [127:0] src,
                                           output bit ill);
        int          opc;
        bit          u;
        bit          q;
        int          sz;
        int          w;
        int          lanes;
        logic [63:0] m;
        logic [127:0] res;
        opc   = int'(ins[16:12]);
        u     = ins[29];
        q     = ins[30];
        sz    = int'(ins[23:22]);
        w     = 8 << sz;
        lanes = (q ? 128 : 64) / w;
        m     = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        res   = '0;
        ill   = !(opc >= 8 && opc <= 11) || (opc == 10 && u) || (sz == 3 && !q);
        if (ill) return '0;
        for (int i = 0; i < lanes; i++) begin
            logic [63:0] v;
            logic [63:0] mn;
            logic [63:0] r;
            bit          ng;
            bit          z;
            bit          t;
            v  = 64'((src >> (i * w)) & {64'd0, m});
            ng = v[w-1];
            z  = (v == 64'd0);
            mn = (~v + 64'd1) & m;
            t  = 1'b0;
            case (opc)
                8:       t = u ? !ng : (!ng && !z);
                9:       t = u ? (ng || z) : z;
                10:      t = ng;
                default: t = 1'b0;
            endcase
            if (opc == 11) r = u ? mn : ((!ng && !z) ? v : mn);
            else           r = t ? m : 64'd0;
            res = res | ({64'd0, r} << (i * w));
        end
        return res;
    endfunction

    function automatic string tag_of(input logic [31:0] ins, input bit ill);
        if (ill) return (ins[23:22] == 2'd3 && !ins[30]) ? "R5" : "R6";
        if (ins[16:12] == 5'h0B) return ins[29] ? "R4" : "R3";
        return "R2";
    endfunction

    task automatic apply(input logic [31:0] ins, input logic [127:0] src);
        logic [127:0] exp;
        bit           ill;
        exp = model(ins, src, ill);
        @(negedge clk);
        in_valid = 1'b1;
        insn     = ins;
        src_vec  = src;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", "out_valid", {127'd0, out_valid}, 128'd1);
        chk(tag_of(ins, ill), "out_vec", out_vec, exp);
        chk(ill ? tag_of(ins, ill) : "R1", "out_illegal", {127'd0, out_illegal}, {127'd0, ill});
        chk("R1", "out_dst", {123'd0, out_dst}, {123'd0, ins[4:0]});
        if (!ins[30]) chk("R7", "upper half", {64'd0, out_vec[127:64]}, 128'd0);
    endtask

    function automatic logic [127:0] extreme_vec();
        logic [127:0] v;
        logic [7:0]   pool [5];
        pool[0] = 8'h00; pool[1] = 8'h01; pool[2] = 8'h7F; pool[3] = 8'h80; pool[4] = 8'hFF;
        v = '0;
        for (int b = 0; b < 16; b++) v[b*8 +: 8] = pool[$urandom_range(0, 4)];
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'h5EED_1234));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        insn     = '0;
        src_vec  = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset out_valid", {127'd0, out_valid}, 128'd0);
        chk("R9", "reset out_vec", out_vec, 128'd0);
        chk("R9", "reset out_dst/illegal", {122'd0, out_dst, out_illegal}, 128'd0);
        rst_n = 1'b1;

        // R3: wrap of most negative byte, zero, minus one
        apply(mk(11, 0, 1, 0, 3, 0), 128'h05_FF_00_80);
        chk("R3", "abs lanes", {96'd0, out_vec[31:0]}, {96'd0, 32'h05_01_00_80});
        // R4: negate wraps, no saturation
        apply(mk(11, 1, 1, 1, 4, 0), 128'h0001_8000_0000_7FFF);
        chk("R4", "neg lanes", {64'd0, out_vec[63:0]}, {64'd0, 64'hFFFF_8000_0000_8001});
        // R2: strict vs non-strict on zero
        apply(mk(8, 0, 1, 2, 5, 0), '0);
        chk("R2", "gt on zero", out_vec, 128'd0);
        apply(mk(9, 1, 1, 2, 6, 0), '0);
        chk("R2", "le on zero", out_vec, {128{1'b1}});
        apply(mk(10, 0, 1, 3, 7, 0), {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF});
        chk("R2", "lt 64-bit lanes", out_vec, {{64{1'b1}}, 64'd0});
        // R5: 64-bit elements, half width
        apply(mk(11, 0, 0, 3, 8, 0), {128{1'b1}});
        chk("R5", "illegal flag", {127'd0, out_illegal}, 128'd1);
        // R6: opcode 0xA with U=1, and an out-of-range opcode
        apply(mk(10, 1, 1, 0, 9, 0), {128{1'b1}});
        chk("R6", "cmlt u1 zero result", out_vec, 128'd0);
        apply(mk(12, 0, 1, 0, 9, 0), {128{1'b1}});
        chk("R6", "bad opcode flag", {127'd0, out_illegal}, 128'd1);
        // R7: half width with negative input everywhere
        apply(mk(11, 1, 0, 0, 10, 0), {128{1'b1}});
        chk("R7", "half upper zero", out_vec, {64'd0, {8{8'h01}}});

        // R8: hold while idle, with changing inputs
        held = out_vec;
        @(negedge clk);
        insn    = mk(8, 0, 1, 0, 31, 0);
        src_vec = {128{1'b1}};
        @(negedge clk);
        chk("R8", "idle out_valid", {127'd0, out_valid}, 128'd0);
        chk("R8", "idle hold vec", out_vec, held);
        chk("R8", "idle hold dst", {123'd0, out_dst}, {123'd0, 5'd10});

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [127:0] s;
            logic [31:0]  ins;
            int           pat;
            pat = $urandom_range(0, 3);
            case (pat)
                0:       s = {$urandom, $urandom, $urandom, $urandom};
                1:       s = '0;
                2:       s = {$urandom, $urandom, $urandom, $urandom}
                           & {$urandom, $urandom, $urandom, $urandom}
                           & {$urandom, $urandom, $urandom, $urandom};
                default: s = extreme_vec();
            endcase
            ins = mk(7 + $urandom_range(0, 5), 1'($urandom), 1'($urandom),
                     $urandom_range(0, 3), $urandom_range(0, 31), $urandom);
            apply(ins, s);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule